// File: doc/BRIEF.md
# RTC Alarm Interrupt Flag Unit

This block holds the interrupt status of a real-time clock and drives the clock's shared active-low interrupt line. It has two alarm channels and one periodic source. The weekly channel fires when the current weekday is one of the days selected in a seven-bit day mask and the BCD hour and minute equal the preset values. The daily channel fires on hour and minute alone.

An alarm flag is not raised at the moment of the match. It is raised a fixed number of 32.768 kHz enable ticks later, two by default, which is about 61 µs. Software can only clear a flag, by writing a zero to its bit. Writing a one leaves the flag as it is. A channel whose enable is low reads its flag as zero and cannot raise it.

The interrupt line is low exactly while at least one readable flag is set. The timekeeping counters and the host bus are outside this block. The bus side is reduced to a one-cycle write strobe with a data word and a read word that is always valid.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset `flags_rd` is 0 and `irq_n` is 1.
- R2: The weekly channel matches when `(wk_days & now_day)` is nonzero, `now_hour == wk_hour` and `now_min == wk_min`. `now_day` is one-hot, with bit k for day k.
- R3: An alarm flag becomes 1 only after `DLY_TICKS` (default 2) cycles with `tick_32k` high have been sampled following the first cycle of a match. After the first tick it still reads 0. In `flags_rd` and `wr_data`, bit 0 is the periodic flag, bit 1 the daily flag and bit 2 the weekly flag.
- R4: A cycle with `wr_stb` high clears every flag whose `wr_data` bit is 0. A 1 in `wr_data` leaves that flag unchanged, whether it is set or clear.
- R5: While a source's enable is 0 its flag reads 0 in the same cycle and cannot become 1. A flag set before the enable dropped is discarded.
- R6: Only the rising edge of a match sets a flag. A flag cleared while the time still matches stays 0. Enabling a channel in the middle of a matching minute does not set it.
- R7: `irq_n` is 0 exactly when `flags_rd` is nonzero.
- R8: A cycle with `per_pulse` high and `per_en` high sets the periodic flag on the next clock edge. It stays set until it is cleared by a write of 0.
- R9: The daily channel matches on `now_hour == day_hour` and `now_min == day_min` for any value of `now_day`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle 32.768 kHz enable |
| now_day | input | ND | Current weekday, one-hot |
| now_hour | input | TW | Current hour, BCD |
| now_min | input | TW | Current minute, BCD |
| wk_days | input | ND | Weekly alarm day mask |
| wk_hour | input | TW | Weekly alarm hour, BCD |
| wk_min | input | TW | Weekly alarm minute, BCD |
| day_hour | input | TW | Daily alarm hour, BCD |
| day_min | input | TW | Daily alarm minute, BCD |
| wk_en | input | 1 | Weekly channel enable |
| day_en | input | 1 | Daily channel enable |
| per_en | input | 1 | Periodic source enable |
| per_pulse | input | 1 | Periodic interrupt event, one cycle |
| wr_stb | input | 1 | Flag write strobe |
| wr_data | input | 3 | Flag write data (0 clears, 1 keeps) |
| flags_rd | output | 3 | Readable flag values |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The bench builds the block with its defaults: 8-bit BCD fields, seven weekdays and a two-tick set delay. With a two-tick delay the multi-stage counter variant is used, so the bench can observe a flag that is still clear after one tick and set after the second. The seven-day mask lets the weekly match be tried with days inside and outside the mask. The daily channel is then shown to set for days the weekly mask rejects.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
   // readable flag bit positions (software-visible)
   localparam int FLG_PER = 0;
   localparam int FLG_DAY = 1;
   localparam int FLG_WK  = 2;
   localparam int NFLG    = 3;

   // alarm channel indices; flag bit = channel + 1
   localparam int CH_DAY  = 0;
   localparam int CH_WK   = 1;
   localparam int NCH     = 2;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          qual,
   input  logic [TW-1:0] now_hour,
   input  logic [TW-1:0] now_min,
   input  logic [TW-1:0] al_hour,
   input  logic [TW-1:0] al_min,
   output logic          rise
);
   logic eq;
   logic eq_q;

   assign eq   = qual && (now_hour == al_hour) && (now_min == al_min);
   assign rise = eq && !eq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_q <= 1'b0;
      else        eq_q <= eq;
   end

   // R6: a match produces one rising event, never two in a row
   a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag #(
   parameter int DLY_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic trig,
   input  logic clr,
   output logic flag
);
   localparam int CW = (DLY_TICKS < 2) ? 1 : $clog2(DLY_TICKS + 1);

   logic fire;

   generate
      if (DLY_TICKS == 1) begin : g_one
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           pend_q <= 1'b0;
            else if (!en)         pend_q <= 1'b0;
            else if (trig)        pend_q <= 1'b1;
            else if (tick)        pend_q <= 1'b0;
         end
         assign fire = pend_q && tick && !trig;
      end else begin : g_cnt
         logic          pend_q;
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               cnt_q  <= '0;
            end else if (!en) begin
               pend_q <= 1'b0;
               cnt_q  <= '0;
            end else if (trig) begin
               pend_q <= 1'b1;
               cnt_q  <= CW'(DLY_TICKS);
            end else if (pend_q && tick) begin
               if (cnt_q == CW'(1)) pend_q <= 1'b0;
               cnt_q <= cnt_q - CW'(1);
            end
         end
         assign fire = pend_q && tick && (cnt_q == CW'(1)) && !trig;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (!en)  flag <= 1'b0;
      else if (fire) flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

   // R3: a flag only rises on a cycle that carried a tick enable
   a_r3_set_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(tick));
   // R5: a disabled channel holds no flag
   a_r5_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !flag);
   // R4: a clear without a competing tick always wins
   a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !tick) |=> !flag);
endmodule

// File: rtl/per_flag.sv
module per_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pulse,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b0;
      else if (!en)   flag <= 1'b0;
      else if (pulse) flag <= 1'b1;
      else if (clr)   flag <= 1'b0;
   end

   // R8: the periodic flag rises only after a periodic event
   a_r8_set_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(pulse && en));
   // R4: a write of 0 without a new event releases the flag
   a_r4_per_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !pulse) |=> !flag);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
   import alarm_irq_pkg::*;
#(
   parameter int TW        = 8,
   parameter int ND        = 7,
   parameter int DLY_TICKS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_32k,
   input  logic [ND-1:0]   now_day,
   input  logic [TW-1:0]   now_hour,
   input  logic [TW-1:0]   now_min,
   input  logic [ND-1:0]   wk_days,
   input  logic [TW-1:0]   wk_hour,
   input  logic [TW-1:0]   wk_min,
   input  logic [TW-1:0]   day_hour,
   input  logic [TW-1:0]   day_min,
   input  logic            wk_en,
   input  logic            day_en,
   input  logic            per_en,
   input  logic            per_pulse,
   input  logic            wr_stb,
   input  logic [NFLG-1:0] wr_data,
   output logic [NFLG-1:0] flags_rd,
   output logic            irq_n
);
   // elaboration checks
   generate
      if (TW < 4)        begin : g_chk_tw  $error("TW must hold one BCD digit"); end
      if (ND < 1)        begin : g_chk_nd  $error("ND must be at least 1");      end
      if (DLY_TICKS < 1) begin : g_chk_dly $error("DLY_TICKS must be >= 1");    end
   endgenerate

   logic [NFLG-1:0] clr;
   logic [NFLG-1:0] flag_q;
   logic [NCH-1:0]  ch_en;
   logic [NCH-1:0]  qual;
   logic [NCH-1:0]  rise;
   logic [TW-1:0]   al_h [NCH];
   logic [TW-1:0]   al_m [NCH];

   assign clr = {NFLG{wr_stb}} & ~wr_data;

   assign al_h[CH_DAY] = day_hour;
   assign al_m[CH_DAY] = day_min;
   assign al_h[CH_WK]  = wk_hour;
   assign al_m[CH_WK]  = wk_min;
   assign ch_en[CH_DAY] = day_en;
   assign ch_en[CH_WK]  = wk_en;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         if (c == CH_WK) begin : g_wk_qual
            assign qual[c] = |(wk_days & now_day);
         end else begin : g_any_day
            assign qual[c] = 1'b1;
         end

         alarm_match #(.TW(TW)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .qual     (qual[c]),
            .now_hour (now_hour),
            .now_min  (now_min),
            .al_hour  (al_h[c]),
            .al_min   (al_m[c]),
            .rise     (rise[c])
         );

         alarm_flag #(.DLY_TICKS(DLY_TICKS)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ch_en[c]),
            .tick  (tick_32k),
            .trig  (rise[c]),
            .clr   (clr[c+1]),
            .flag  (flag_q[c+1])
         );
      end
   endgenerate

   per_flag u_per (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (per_en),
      .pulse (per_pulse),
      .clr   (clr[FLG_PER]),
      .flag  (flag_q[FLG_PER])
   );

   assign flags_rd[FLG_PER] = flag_q[FLG_PER] & per_en;
   assign flags_rd[FLG_DAY] = flag_q[FLG_DAY] & day_en;
   assign flags_rd[FLG_WK]  = flag_q[FLG_WK]  & wk_en;
   assign irq_n = ~|flags_rd;

   // R7: the line only falls after a tick or a periodic event
   a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(tick_32k || per_pulse));
   // R1: released line while nothing is readable
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q == '0) |-> irq_n);
endmodule

// File: tb/sim_alarm_irq_unit.sv
module sim_alarm_irq_unit;
   localparam int PERIOD = 10;
   localparam int WDOG   = 50000;

   typedef struct packed {
      logic [6:0] wd;
      logic [7:0] hr;
      logic [7:0] mn;
      logic       e_wk;
      logic       e_day;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{7'b0000100, 8'h08, 8'h30, 1'b1, 1'b0},
      '{7'b0010000, 8'h08, 8'h30, 1'b1, 1'b0},
      '{7'b0001000, 8'h08, 8'h30, 1'b0, 1'b0},
      '{7'b0000100, 8'h08, 8'h31, 1'b0, 1'b0},
      '{7'b0000001, 8'h12, 8'h45, 1'b0, 1'b1},
      '{7'b1000000, 8'h12, 8'h45, 1'b0, 1'b1},
      '{7'b0000100, 8'h09, 8'h30, 1'b0, 1'b0}
   };

   logic       clk = 0;
   logic       rst_n = 0;
   logic       tick_32k = 0;
   logic [6:0] now_day = 7'b0000001;
   logic [7:0] now_hour = 8'h00, now_min = 8'h00;
   logic [6:0] wk_days = 7'b0010100;
   logic [7:0] wk_hour = 8'h08, wk_min = 8'h30;
   logic [7:0] day_hour = 8'h12, day_min = 8'h45;
   logic       wk_en = 0, day_en = 0, per_en = 0, per_pulse = 0;
   logic       wr_stb = 0;
   logic [2:0] wr_data = 3'b111;
   logic [2:0] flags_rd;
   logic       irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   alarm_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
      .now_day(now_day), .now_hour(now_hour), .now_min(now_min),
      .wk_days(wk_days), .wk_hour(wk_hour), .wk_min(wk_min),
      .day_hour(day_hour), .day_min(day_min),
      .wk_en(wk_en), .day_en(day_en), .per_en(per_en), .per_pulse(per_pulse),
      .wr_stb(wr_stb), .wr_data(wr_data), .flags_rd(flags_rd), .irq_n(irq_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk) tick_32k = 1;
      @(negedge clk) tick_32k = 0;
   endtask

   task automatic wr(input logic [2:0] d);
      @(negedge clk) begin wr_stb = 1; wr_data = d; end
      @(negedge clk) begin wr_stb = 0; wr_data = 3'b111; end
   endtask

   task automatic set_time(input logic [6:0] d, input logic [7:0] h, input logic [7:0] m);
      @(negedge clk) begin now_day = d; now_hour = h; now_min = m; end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      step(3);
      // R1: reset state
      check("R1 flags", 32'(flags_rd), 32'h0);
      check("R1 irq_n", 32'(irq_n), 32'h1);
      @(negedge clk) rst_n = 1;
      wk_en = 1; day_en = 1; per_en = 1;
      step(2);
      check("R1 after release", 32'(flags_rd), 32'h0);

      // R2 R3 R9: table walk
      for (int v = 0; v < NV; v++) begin
         set_time(7'b0000001, 8'h00, 8'h00);
         step(2);
         wr(3'b000);
         set_time(VECS[v].wd, VECS[v].hr, VECS[v].mn);
         step(2);
         tick();
         check("R3 not before second tick", 32'(flags_rd), 32'h0);
         tick();
         check("R2 weekly flag", 32'(flags_rd[2]), 32'(VECS[v].e_wk));
         check("R9 daily flag", 32'(flags_rd[1]), 32'(VECS[v].e_day));
         check("R7 irq level", 32'(irq_n), 32'(!(VECS[v].e_wk || VECS[v].e_day)));
      end

      // R4 R6: write-one ignored, clear by zero, no re-set within the match
      set_time(7'b0000001, 8'h00, 8'h00);
      step(2);
      wr(3'b000);
      set_time(7'b0000100, 8'h08, 8'h30);
      step(2);
      tick(); tick();
      check("R3 weekly set", 32'(flags_rd), 32'h4);
      wr(3'b111);
      check("R4 write one keeps set", 32'(flags_rd), 32'h4);
      wr(3'b011);
      check("R4 write zero clears", 32'(flags_rd), 32'h0);
      check("R7 released", 32'(irq_n), 32'h1);
      tick(); tick(); tick();
      check("R6 stays clear in same match", 32'(flags_rd), 32'h0);
      wr(3'b111);
      check("R4 write one on clear flag", 32'(flags_rd), 32'h0);

      // R5: disabled channel cannot set
      set_time(7'b0000001, 8'h00, 8'h00);
      step(2);
      @(negedge clk) wk_en = 0;
      set_time(7'b0000100, 8'h08, 8'h30);
      step(2);
      tick(); tick(); tick();
      check("R5 disabled no set", 32'(flags_rd), 32'h0);
      @(negedge clk) wk_en = 1;
      tick(); tick(); tick();
      check("R6 enable mid-match no set", 32'(flags_rd), 32'h0);

      // R5: disabling discards a set flag
      set_time(7'b0000001, 8'h00, 8'h00);
      step(2);
      set_time(7'b0000100, 8'h08, 8'h30);
      step(2);
      tick(); tick();
      check("R3 set again", 32'(flags_rd), 32'h4);
      @(negedge clk) wk_en = 0;
      #1;
      check("R5 reads zero when off", 32'(flags_rd), 32'h0);
      check("R7 irq released when off", 32'(irq_n), 32'h1);
      @(negedge clk) wk_en = 1;
      step(1);
      check("R5 discarded on re-enable", 32'(flags_rd), 32'h0);

      // R8: periodic flag
      set_time(7'b0000001, 8'h00, 8'h00);
      @(negedge clk) per_pulse = 1;
      @(negedge clk) per_pulse = 0;
      check("R8 periodic set", 32'(flags_rd), 32'h1);
      check("R7 irq low", 32'(irq_n), 32'h0);
      wr(3'b111);
      check("R4 periodic write one", 32'(flags_rd), 32'h1);
      wr(3'b110);
      check("R8 periodic cleared", 32'(flags_rd), 32'h0);
      check("R7 irq high", 32'(irq_n), 32'h1);
      @(negedge clk) per_en = 0;
      @(negedge clk) per_pulse = 1;
      @(negedge clk) per_pulse = 0;
      check("R5 periodic disabled", 32'(flags_rd), 32'h0);

      done = 1;
      summary();
      $finish;
   end
endmodule